// File: doc/BRIEF.md
# SD Host Controller Register Front End

This block sits between a 32-bit register bus and an SD/eMMC slot controller. It decodes a 4 KiB window. The lower 512 bytes hold a small vendor host register set. It has three registers with side effects: a general register with a self-clearing soft reset, a PHY access port that acknowledges a request at once, and an eMMC control word whose tuning bit never sticks. All other words in that range are plain storage.

Requests at byte offset 0x200 and above go out on a separate slot request port, with the offset moved down by 0x200. Read data coming back from the slot is merged onto the same response channel. The block emits a one-cycle reset pulse to the slot controller after a system reset and after a soft reset. The slot interrupt passes straight through to the block's interrupt output.

Top module: `sdhc_regwrap`

## Requirements
- R1: After reset, the word at offset 0x000 reads 0x00010000 and every other host word reads 0.
- R2: A host read returns the stored word with `rsp_valid` high in the cycle after acceptance. The word index is address bits [8:2], and address bits [1:0] are ignored.
- R3: A write to offset 0x000 with bit 0 set clears every host word and reloads 0x00010000 into offset 0x000. A write to offset 0x000 with bit 0 clear leaves every host word unchanged.
- R4: A write to offset 0x010 stores its data with bit 26 replaced: bit 26 is set to 1 when bit 24 or bit 25 is set, and to 0 otherwise.
- R5: A write to offset 0x018 stores its data with bit 15 forced to 0.
- R6: A write to any other host offset from 0x004 to 0x1FC is stored unchanged and reads back as written.
- R7: A request at offset 0x200 or higher drives `slot_req_valid` with `slot_req_addr` equal to the offset minus 0x200, and with the same write flag and data. It leaves the host words unchanged, and `req_ready` follows `slot_req_ready`.
- R8: A slot response (`slot_rsp_valid`, `slot_rsp_rdata`) appears unchanged on `rsp_valid` and `rsp_rdata` in the same cycle.
- R9: `irq` equals `slot_irq` at all times.
- R10: `slot_rst` is high for exactly one cycle after reset is released, and for exactly one cycle after an accepted soft-reset write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| slot_req_valid | output | 1 | Forwarded request valid |
| slot_req_ready | input | 1 | Slot accepts the forwarded request |
| slot_req_write | output | 1 | Forwarded write flag |
| slot_req_addr | output | 12 | Forwarded byte offset (minus 0x200) |
| slot_req_wdata | output | 32 | Forwarded write data |
| slot_rsp_valid | input | 1 | Slot read data valid |
| slot_rsp_rdata | input | 32 | Slot read data |
| slot_irq | input | 1 | Slot controller interrupt |
| irq | output | 1 | Block interrupt |
| slot_rst | output | 1 | One-cycle reset pulse to the slot controller |

## Verification
The hardest case to reach is a soft reset that must undo state that several earlier writes built up. A reset pulse that only reloads offset 0x000 would still leave a fresh design looking correct. The bench therefore fills scattered words first, including the top word 0x1FC and the PHY port with its acknowledge set. It then issues the soft reset and reads each word back. Holding `slot_req_ready` low while a request targets the slot range also shows whether back-pressure passes through, and whether a host word with the same low offset stays untouched.

// File: rtl/sdhc_regwrap_pkg.sv
// Package: shared constants for the SD host register front end.
// Assumes a 32-bit data bus and a byte-addressed 12-bit window.
package sdhc_regwrap_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned SLOT_BASE  = 12'h200;
    localparam int unsigned HOST_WORDS = SLOT_BASE / 4;
    localparam int unsigned IDX_W      = $clog2(HOST_WORDS);

    // Word indices of registers with side effects
    localparam int unsigned IDX_GEN    = 0;
    localparam int unsigned IDX_PHY    = 4;
    localparam int unsigned IDX_EMMC   = 6;

    // Bit positions
    localparam int unsigned BIT_SRST   = 0;
    localparam int unsigned BIT_PHY_WR = 24;
    localparam int unsigned BIT_PHY_RD = 25;
    localparam int unsigned BIT_PHY_AK = 26;
    localparam int unsigned BIT_TUNE   = 15;

    localparam logic [31:0] GEN_POR    = 32'h0001_0000;
endpackage

// File: rtl/sdhc_addr_decode.sv
// Module: address decode. Splits a request between the host register set
// and the slot port. Assumes the host set occupies offsets below SLOT_BASE.
module sdhc_addr_decode #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SLOT_BASE = 12'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              slot_req_ready,
    output logic              host_sel,
    output logic              slot_req_valid,
    output logic [ADDR_W-1:0] slot_req_addr,
    output logic              req_ready
);
    logic in_slot;

    // Route the request by comparing against the slot base
    always_comb begin
        in_slot        = (req_addr >= ADDR_W'(SLOT_BASE));
        host_sel       = req_valid && !in_slot;
        slot_req_valid = req_valid && in_slot;
        slot_req_addr  = req_addr - ADDR_W'(SLOT_BASE);
        req_ready      = in_slot ? slot_req_ready : 1'b1;
    end

    // R7: a high-range request never selects the host set
    p_slot_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= ADDR_W'(SLOT_BASE)) |-> (slot_req_valid && !host_sel));
endmodule

// File: rtl/sdhc_host_regs.sv
// Module: host register file with write side effects.
// Soft reset clears all words and reloads the general word; the PHY port
// acknowledge follows its request bits; the tuning bit is never stored.
// Assumes full-word accesses; reads respond one cycle after acceptance.
module sdhc_host_regs
    import sdhc_regwrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              soft_rst
);
    logic [DATA_W-1:0] mem [HOST_WORDS];
    logic [DATA_W-1:0] wval;
    logic              do_wr;

    // Detect an accepted soft-reset write
    always_comb begin
        do_wr    = sel && wr;
        soft_rst = do_wr && (idx == IDX_W'(IDX_GEN)) && wdata[BIT_SRST];
    end

    // Shape the value to store for the addressed word
    always_comb begin
        wval = wdata;
        if (idx == IDX_W'(IDX_PHY))
            wval[BIT_PHY_AK] = wdata[BIT_PHY_WR] | wdata[BIT_PHY_RD];
        else if (idx == IDX_W'(IDX_EMMC))
            wval[BIT_TUNE] = 1'b0;
    end

    // Storage: reset or soft reset restore defaults, writes store shaped data
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int i = 0; i < int'(HOST_WORDS); i++)
                mem[i] <= (i == int'(IDX_GEN)) ? GEN_POR : '0;
        end else if (do_wr && idx != IDX_W'(IDX_GEN)) begin
            mem[idx] <= wval;
        end
    end

    // Read port with one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= sel && !wr;
            rd_data  <= mem[idx];
        end
    end

    // R2: every accepted host read responds on the next cycle
    p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |=> rd_valid);
    // R3: after a soft reset the general word holds its power-on value
    p_srst_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mem[IDX_GEN] == GEN_POR && mem[IDX_PHY] == '0));
    // R4: acknowledge bit tracks the written request bits
    p_phy_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && idx == IDX_W'(IDX_PHY)) |=>
        (mem[IDX_PHY][BIT_PHY_AK] == ($past(wdata[BIT_PHY_WR]) | $past(wdata[BIT_PHY_RD]))));
    // R5: tuning bit reads zero after any control write
    p_tune_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && idx == IDX_W'(IDX_EMMC)) |=> (mem[IDX_EMMC][BIT_TUNE] == 1'b0));
endmodule

// File: rtl/sdhc_slot_rst_gen.sv
// Module: slot reset pulse generator. Emits one cycle of reset after
// system reset is released and after each soft reset request.
module sdhc_slot_rst_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    output logic pulse
);
    logic armed;

    // Arm on system reset, fire once on release or on soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            pulse <= 1'b0;
        end else begin
            armed <= 1'b0;
            pulse <= armed | soft_rst;
        end
    end

    // R10: the pulse lasts one cycle unless a new soft reset arrives
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !soft_rst) |=> !pulse);
endmodule

// File: rtl/sdhc_regwrap.sv
// Module: top of the SD host register front end. Decodes the window,
// keeps the host register set, forwards high offsets to the slot port,
// merges responses and passes the slot interrupt through.
module sdhc_regwrap
    import sdhc_regwrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              slot_req_valid,
    input  logic              slot_req_ready,
    output logic              slot_req_write,
    output logic [ADDR_W-1:0] slot_req_addr,
    output logic [DATA_W-1:0] slot_req_wdata,
    input  logic              slot_rsp_valid,
    input  logic [DATA_W-1:0] slot_rsp_rdata,
    input  logic              slot_irq,
    output logic              irq,
    output logic              slot_rst
);
    logic              host_sel;
    logic              host_rd_valid;
    logic [DATA_W-1:0] host_rd_data;
    logic              soft_rst;

    sdhc_addr_decode #(.ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE)) u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .slot_req_ready (slot_req_ready),
        .host_sel       (host_sel),
        .slot_req_valid (slot_req_valid),
        .slot_req_addr  (slot_req_addr),
        .req_ready      (req_ready)
    );

    sdhc_host_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (host_sel),
        .wr       (req_write),
        .idx      (req_addr[IDX_W+1:2]),
        .wdata    (req_wdata),
        .rd_valid (host_rd_valid),
        .rd_data  (host_rd_data),
        .soft_rst (soft_rst)
    );

    sdhc_slot_rst_gen u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .pulse    (slot_rst)
    );

    // Forward the write flag and data, merge responses, pass the interrupt
    always_comb begin
        slot_req_write = req_write;
        slot_req_wdata = req_wdata;
        rsp_valid      = host_rd_valid | slot_rsp_valid;
        rsp_rdata      = host_rd_valid ? host_rd_data : slot_rsp_rdata;
        irq            = slot_irq;
    end
endmodule

// File: tb/tb_sdhc_regwrap.sv
module tb_sdhc_regwrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        slot_req_valid, slot_req_write;
    logic        slot_req_ready = 1'b1;
    logic [11:0] slot_req_addr;
    logic [31:0] slot_req_wdata;
    logic        slot_rsp_valid = 1'b0;
    logic [31:0] slot_rsp_rdata = '0;
    logic        slot_irq = 1'b0;
    logic        irq, slot_rst;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    sdhc_regwrap dut (.*);

    // vector: {addr[11:0], write data, expected read-back}
    localparam logic [75:0] VEC [8] = '{
        {12'h004, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R6
        {12'h010, 32'h0100_0055, 32'h0500_0055},  // R4 write request
        {12'h010, 32'h0200_0000, 32'h0600_0000},  // R4 read request
        {12'h010, 32'h0400_0012, 32'h0000_0012},  // R4 no request
        {12'h018, 32'h0000_FFFF, 32'h0000_7FFF},  // R5
        {12'h018, 32'h0000_8001, 32'h0000_0001},  // R5
        {12'h1FC, 32'h1234_5678, 32'h1234_5678},  // R6 top word
        {12'h000, 32'hFFFF_FFFE, 32'h0001_0000}   // R3 no soft reset
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        check(req, {31'b0, rsp_valid}, 32'd1);
        d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 pulse after reset", {31'b0, slot_rst}, 32'd1);
        @(negedge clk);
        check("R10 pulse one cycle", {31'b0, slot_rst}, 32'd0);
        bus_read(12'h000, rd, "R2"); check("R1 word0", rd, 32'h0001_0000);
        bus_read(12'h010, rd, "R2"); check("R1 phy", rd, 32'h0);
        bus_read(12'h1FC, rd, "R2"); check("R1 top", rd, 32'h0);

        for (int i = 0; i < 8; i++) begin
            bus_write(VEC[i][75:64], VEC[i][63:32]);
            bus_read(VEC[i][75:64], rd, "R2");
            check("R3/R4/R5/R6 vector", rd, VEC[i][31:0]);
        end

        // R2 low address bits ignored
        bus_read(12'h006, rd, "R2"); check("R2 low bits", rd, 32'hDEAD_BEEF);

        // R3 soft reset after state built up
        bus_write(12'h010, 32'h0100_0000);
        bus_write(12'h034, 32'h0000_A5A5);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h000; req_wdata = 32'h1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R10 soft pulse", {31'b0, slot_rst}, 32'd1);
        @(negedge clk);
        check("R10 soft pulse ends", {31'b0, slot_rst}, 32'd0);
        bus_read(12'h000, rd, "R2"); check("R3 word0 reload", rd, 32'h0001_0000);
        bus_read(12'h004, rd, "R2"); check("R3 cleared 004", rd, 32'h0);
        bus_read(12'h010, rd, "R2"); check("R3 cleared phy", rd, 32'h0);
        bus_read(12'h1FC, rd, "R2"); check("R3 cleared top", rd, 32'h0);

        // R7 forwarding with back-pressure
        bus_write(12'h034, 32'h0000_A5A5);
        @(negedge clk);
        slot_req_ready = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h234; req_wdata = 32'hCAFE_0001;
        #1;
        check("R7 slot valid", {31'b0, slot_req_valid}, 32'd1);
        check("R7 slot addr", {20'b0, slot_req_addr}, 32'h034);
        check("R7 slot data", slot_req_wdata, 32'hCAFE_0001);
        check("R7 slot write", {31'b0, slot_req_write}, 32'd1);
        check("R7 ready low", {31'b0, req_ready}, 32'd0);
        slot_req_ready = 1'b1;
        #1;
        check("R7 ready high", {31'b0, req_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        bus_read(12'h034, rd, "R2"); check("R7 host untouched", rd, 32'h0000_A5A5);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 12'hFFC;
        #1;
        check("R7 top addr", {20'b0, slot_req_addr}, 32'hDFC);
        @(negedge clk);
        req_valid = 1'b0;

        // R8 slot response merge
        slot_rsp_valid = 1'b1; slot_rsp_rdata = 32'h5A5A_1234;
        #1;
        check("R8 rsp valid", {31'b0, rsp_valid}, 32'd1);
        check("R8 rsp data", rsp_rdata, 32'h5A5A_1234);
        @(negedge clk);
        slot_rsp_valid = 1'b0;
        #1;
        check("R8 rsp idle", {31'b0, rsp_valid}, 32'd0);

        // R9 interrupt pass-through
        slot_irq = 1'b1; #1;
        check("R9 irq high", {31'b0, irq}, 32'd1);
        slot_irq = 1'b0; #1;
        check("R9 irq low", {31'b0, irq}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule